// File: doc/BRIEF.md
# ADC Scan DMA Sequencer

This block walks a group of ADC input channels on its own and stores each conversion result in an on-chip register file. Software programs two 8-bit registers. The control register holds a run bit, an interrupt bit and a last-channel number. The base register supplies the upper address bits. After that, the block runs without help. Starting at channel 0, it requests one conversion per channel from an external converter and waits for the result. It then stores the result as two byte writes in a two-byte slot whose position depends on the channel number.

When the last programmed channel has been stored, the channel counter returns to 0 and the scan starts again. The scan repeats for as long as the run bit stays set. If interrupts are enabled, a one-cycle interrupt pulse marks the end of each complete pass. A new last-channel value written while a pass is in progress does not take effect until the next pass begins. Clearing the run bit halts the block at once and returns it to channel 0.

Top module: `adc_scan_dma`

## Requirements
- R1: After reset the control readback is 0x00, and `conv_start`, `mem_we` and `scan_irq` are all low.
- R2: A control write stores bit 7 (run), bit 6 (interrupt enable) and bits 3:0 (last channel). Bits 5:4 always read back as 0, so writing 0x7F reads back 0x4F.
- R3: With last channel N, conversions are requested for channels 0, 1, ..., N in order. Each request is a one-cycle `conv_start` pulse, and `conv_chan` carries the channel number.
- R4: After a request, the block waits as long as needed for `conv_done`. A `conv_done` pulse that arrives while no conversion is outstanding is ignored and changes no stored data.
- R5: The write address for channel c is {base[7:1], c[3:0], b}, where b is 0 for the high byte and 1 for the low byte. Base bit 0 has no effect.
- R6: Each result causes two single-cycle write strobes on consecutive cycles. The first writes result bits 15:8 to the even address, and the second writes bits 7:0 to the odd address.
- R7: After channel N is stored, the scan continues from channel 0 again, without limit, while run stays set.
- R8: If interrupt enable is set, `scan_irq` is high for exactly one cycle, two cycles after the low-byte write of channel N. If interrupt enable is clear, `scan_irq` never goes high.
- R9: Clearing run stops all requests and writes. The next time run is set, the scan starts at channel 0.
- R10: A change to the last-channel field while the block is running takes effect only when the scan wraps to channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register readback |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | 8 | Base write data |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel being converted |
| conv_done | input | 1 | Conversion result valid pulse |
| conv_data | input | 16 | Conversion result |
| mem_we | output | 1 | Register file byte write strobe |
| mem_addr | output | 12 | Register file byte address |
| mem_wdata | output | 8 | Register file byte data |
| scan_irq | output | 1 | End-of-pass interrupt pulse |

## Verification
The bench drives the wrap from channel N to 0 over several passes. A counter that skipped the wrap, or that wrote an extra channel, would produce addresses missing from the scoreboard. The last-channel field is rewritten in the middle of a pass. A design that applied it at once would cut that pass short, or stretch it, and would fire the interrupt at the wrong point. The run bit is also cleared in the middle of a scan. A design that kept the counter value would resume at channel 2 instead of 0. A stray done pulse is sent while the block is idle. A design that latched it would write 0xDEAD bytes, or would step ahead without waiting for its own conversion.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_BUSY  = 3'd2,
      ST_WR_HI = 3'd3,
      ST_WR_LO = 3'd4,
      ST_ADV   = 3'd5
   } scan_state_t;

   // byte select within a channel slot
   localparam logic BYTE_HI = 1'b0;
   localparam logic BYTE_LO = 1'b1;

endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs #(
   parameter int REG_W  = 8,
   parameter int CHAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [REG_W-1:0]  ctrl_wdata,
   input  logic              base_wr,
   input  logic [REG_W-1:0]  base_wdata,
   output logic              cfg_run,
   output logic              cfg_irq_en,
   output logic [CHAN_W-1:0] cfg_last,
   output logic [REG_W-2:0]  cfg_base_hi,
   output logic [REG_W-1:0]  ctrl_rdata
);
   localparam int RUN_BIT = REG_W - 1;
   localparam int IRQ_BIT = REG_W - 2;

   if (CHAN_W > REG_W - 2) begin : g_bad_chan_w
      $error("adc_scan_regs: last-channel field overlaps control flags");
   end

   logic              run_q;
   logic              irq_en_q;
   logic [CHAN_W-1:0] last_q;
   logic [REG_W-2:0]  base_q;
   logic              unused_wbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         irq_en_q <= 1'b0;
         last_q   <= '0;
      end else if (ctrl_wr) begin
         run_q    <= ctrl_wdata[RUN_BIT];
         irq_en_q <= ctrl_wdata[IRQ_BIT];
         last_q   <= ctrl_wdata[CHAN_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (base_wr) begin
         base_q <= base_wdata[REG_W-1:1];
      end
   end

   // readback: reserved positions are tied low
   always_comb begin
      ctrl_rdata = '0;
      for (int i = 0; i < REG_W; i++) begin
         if (i == RUN_BIT)      ctrl_rdata[i] = run_q;
         else if (i == IRQ_BIT) ctrl_rdata[i] = irq_en_q;
         else if (i < CHAN_W)   ctrl_rdata[i] = last_q[i];
      end
   end

   assign unused_wbits = ^{ctrl_wdata[IRQ_BIT-1:CHAN_W], base_wdata[0]};

   assign cfg_run     = run_q;
   assign cfg_irq_en  = irq_en_q;
   assign cfg_last    = last_q;
   assign cfg_base_hi = base_q;

endmodule

// File: rtl/adc_scan_chan.sv
module adc_scan_chan #(
   parameter int CHAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              idle,
   input  logic              step,
   input  logic [CHAN_W-1:0] cfg_last,
   output logic [CHAN_W-1:0] cur_chan,
   output logic              at_last
);
   localparam logic [CHAN_W-1:0] CH_ONE = {{(CHAN_W-1){1'b0}}, 1'b1};

   logic [CHAN_W-1:0] cur_q;
   logic [CHAN_W-1:0] last_act_q;

   assign at_last = (cur_q == last_act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q      <= '0;
         last_act_q <= '0;
      end else if (!run || idle) begin
         cur_q      <= '0;
         last_act_q <= cfg_last;
      end else if (step) begin
         if (at_last) begin
            cur_q      <= '0;
            last_act_q <= cfg_last;   // new limit applies per pass
         end else begin
            cur_q <= cur_q + CH_ONE;
         end
      end
   end

   assign cur_chan = cur_q;

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
   import adc_scan_pkg::*;
#(
   parameter int RES_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              irq_en,
   input  logic              at_last,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   output logic              conv_start,
   output logic              idle,
   output logic              step,
   output logic              wr_en,
   output logic              byte_sel,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              irq
);
   localparam int SLOT_W = 2 * BYTE_W;

   if (RES_W > SLOT_W || RES_W <= BYTE_W) begin : g_bad_res_w
      $error("adc_scan_fsm: result width must fit a two-byte slot");
   end

   scan_state_t       st_q, st_d;
   logic [SLOT_W-1:0] res_q;
   logic [SLOT_W-1:0] res_ext;
   logic              irq_q;

   // result widening variant
   if (RES_W == SLOT_W) begin : g_full
      assign res_ext = conv_data;
   end else begin : g_pad
      assign res_ext = {{(SLOT_W-RES_W){1'b0}}, conv_data};
   end

   always_comb begin
      st_d = st_q;
      if (!run) begin
         st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE:  st_d = ST_START;
            ST_START: st_d = ST_BUSY;
            ST_BUSY:  st_d = conv_done ? ST_WR_HI : ST_BUSY;
            ST_WR_HI: st_d = ST_WR_LO;
            ST_WR_LO: st_d = ST_ADV;
            ST_ADV:   st_d = ST_START;
            default:  st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (st_q == ST_BUSY && conv_done) begin
         res_q <= res_ext;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= step && at_last && irq_en;
      end
   end

   assign conv_start = run && (st_q == ST_START);
   assign idle       = (st_q == ST_IDLE);
   assign step       = run && (st_q == ST_ADV);
   assign wr_en      = run && (st_q == ST_WR_HI || st_q == ST_WR_LO);
   assign byte_sel   = (st_q == ST_WR_LO) ? BYTE_LO : BYTE_HI;
   assign wr_byte    = byte_sel ? res_q[BYTE_W-1:0] : res_q[SLOT_W-1:BYTE_W];
   assign irq        = irq_q;

endmodule

// File: rtl/adc_scan_dma.sv
module adc_scan_dma #(
   parameter int REG_W  = 8,
   parameter int CHAN_W = 4,
   parameter int RES_W  = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = (REG_W - 1) + CHAN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [REG_W-1:0]  ctrl_wdata,
   output logic [REG_W-1:0]  ctrl_rdata,
   input  logic              base_wr,
   input  logic [REG_W-1:0]  base_wdata,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              scan_irq
);
   localparam int ADDR_CALC = (REG_W - 1) + CHAN_W + 1;

   if (ADDR_W != ADDR_CALC) begin : g_bad_addr_w
      $error("adc_scan_dma: ADDR_W must equal base, channel and byte bits");
   end

   logic              cfg_run;
   logic              cfg_irq_en;
   logic [CHAN_W-1:0] cfg_last;
   logic [REG_W-2:0]  cfg_base_hi;
   logic [CHAN_W-1:0] cur_chan;
   logic              at_last;
   logic              idle;
   logic              step;
   logic              byte_sel;

   adc_scan_regs #(.REG_W(REG_W), .CHAN_W(CHAN_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_wr     (ctrl_wr),
      .ctrl_wdata  (ctrl_wdata),
      .base_wr     (base_wr),
      .base_wdata  (base_wdata),
      .cfg_run     (cfg_run),
      .cfg_irq_en  (cfg_irq_en),
      .cfg_last    (cfg_last),
      .cfg_base_hi (cfg_base_hi),
      .ctrl_rdata  (ctrl_rdata)
   );

   adc_scan_chan #(.CHAN_W(CHAN_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (cfg_run),
      .idle     (idle),
      .step     (step),
      .cfg_last (cfg_last),
      .cur_chan (cur_chan),
      .at_last  (at_last)
   );

   adc_scan_fsm #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (cfg_run),
      .irq_en     (cfg_irq_en),
      .at_last    (at_last),
      .conv_done  (conv_done),
      .conv_data  (conv_data),
      .conv_start (conv_start),
      .idle       (idle),
      .step       (step),
      .wr_en      (mem_we),
      .byte_sel   (byte_sel),
      .wr_byte    (mem_wdata),
      .irq        (scan_irq)
   );

   // slot address: base high bits, channel, byte within slot
   assign mem_addr  = {cfg_base_hi, cur_chan, byte_sel};
   assign conv_chan = cur_chan;

endmodule

// File: rtl/adc_scan_dma_chk.sv
module adc_scan_dma_chk #(
   parameter int REG_W  = 8,
   parameter int CHAN_W = 4,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_W-1:0]  ctrl_rdata,
   input logic              base_wr,
   input logic              conv_start,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              scan_irq
);
   localparam logic [REG_W-1:0] RSV_MASK =
      ((REG_W'(1) << (REG_W - 2)) - REG_W'(1)) & ~((REG_W'(1) << CHAN_W) - REG_W'(1));

   // R2: reserved control bits never read as 1
   assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rdata & RSV_MASK) == '0);

   // R3: request is a single-cycle pulse
   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R6: low-byte strobe follows high-byte strobe unless run was cleared
   assert_lo_follows_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_addr[0]) |=> ((mem_we && mem_addr[0]) || !ctrl_rdata[REG_W-1]));

   // R5 R6: both bytes of a result land in the same slot
   assert_same_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !mem_addr[0]) |=>
         (!mem_we || base_wr || $past(base_wr) || mem_addr[ADDR_W-1:1] == $past(mem_addr[ADDR_W-1:1])));

   // R8: interrupt is one cycle wide
   assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_irq |=> !scan_irq);

   // R8: interrupt only with interrupt enable set
   assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_irq |-> $past(ctrl_rdata[REG_W-2]));

   // R9: no requests and no writes while stopped
   assert_quiet_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_rdata[REG_W-1] |-> (!conv_start && !mem_we));

endmodule

bind adc_scan_dma adc_scan_dma_chk #(.REG_W(REG_W), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_rdata (ctrl_rdata),
   .base_wr    (base_wr),
   .conv_start (conv_start),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .scan_irq   (scan_irq)
);

// File: tb/sim_adc_scan_dma.sv
`timescale 1ns/1ps
module sim_adc_scan_dma;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [7:0]  ctrl_wdata = '0;
   logic [7:0]  ctrl_rdata;
   logic        base_wr = 1'b0;
   logic [7:0]  base_wdata = '0;
   logic        conv_start;
   logic [3:0]  conv_chan;
   logic        conv_done;
   logic [15:0] conv_data;
   logic        mem_we;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        scan_irq;

   logic        mdl_done = 1'b0;
   logic [15:0] mdl_data = '0;
   logic        stray_done = 1'b0;

   assign conv_done = mdl_done | stray_done;
   assign conv_data = stray_done ? 16'hDEAD : mdl_data;

   always #10 clk = ~clk;   // 50 MHz

   adc_scan_dma u0 (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
      .base_wr(base_wr), .base_wdata(base_wdata),
      .conv_start(conv_start), .conv_chan(conv_chan),
      .conv_done(conv_done), .conv_data(conv_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .scan_irq(scan_irq)
   );

   typedef struct {
      logic [11:0] addr;
      logic [7:0]  data;
      bit          irq;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   irq_due = -10;
   int   exp_idx = 0;
   int   mdl_idx = 0;
   bit   ended = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // converter model: variable latency, result = {channel, running index}
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            automatic logic [3:0] ch = conv_chan;
            automatic int dly = 1 + (mdl_idx % 4);
            automatic logic [11:0] idx = mdl_idx[11:0];
            mdl_idx++;
            repeat (dly) @(negedge clk);
            mdl_data = {ch, idx};
            mdl_done = 1'b1;
            @(negedge clk);
            mdl_done = 1'b0;
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         if (mem_we) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R7/R9 unexpected write", int'(mem_addr), 0);
            end else begin
               automatic exp_t e = exp_q.pop_front();
               check(mem_addr == e.addr, "R5 address", int'(mem_addr), int'(e.addr));
               check(mem_wdata == e.data, "R6 byte data", int'(mem_wdata), int'(e.data));
               if (e.irq) irq_due = cyc + 2;
            end
         end
         if (scan_irq) check(cyc == irq_due, "R8 irq timing", cyc, irq_due);
         else if (cyc == irq_due) check(1'b0, "R8 irq missing", 0, 1);
      end
   end

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic wr_base(input logic [7:0] v);
      @(negedge clk);
      base_wr = 1'b1; base_wdata = v;
      @(negedge clk);
      base_wr = 1'b0;
   endtask

   // driver: expected bytes for channels lo..hi of a pass ending at pass_last
   task automatic push_chans(input logic [7:0] base, input int lo, input int hi,
                             input int pass_last, input bit irq_on);
      for (int ch = lo; ch <= hi; ch++) begin
         automatic logic [15:0] d = {ch[3:0], exp_idx[11:0]};
         automatic exp_t eh, el;
         exp_idx++;
         eh.addr = {base[7:1], ch[3:0], 1'b0}; eh.data = d[15:8]; eh.irq = 1'b0;
         el.addr = {base[7:1], ch[3:0], 1'b1}; el.data = d[7:0];
         el.irq  = irq_on && (ch == pass_last);
         exp_q.push_back(eh);
         exp_q.push_back(el);
      end
   endtask

   task automatic drain_and_stop();
      wait (exp_q.size() == 0);
      @(negedge clk);
      ctrl_wr = 1'b1; ctrl_wdata = 8'h00;
      @(negedge clk);
      ctrl_wr = 1'b0;
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, "R9 stopped", exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(ctrl_rdata == 8'h00, "R1 ctrl reset", ctrl_rdata, 0);
      check(!conv_start && !mem_we && !scan_irq, "R1 outputs idle",
            {conv_start, mem_we, scan_irq}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: readback with reserved bits masked (run left clear)
      wr_ctrl(8'h7F);
      check(ctrl_rdata == 8'h4F, "R2 readback", ctrl_rdata, 8'h4F);
      check(!conv_start && !mem_we, "R9 no activity with run clear", {conv_start, mem_we}, 0);
      wr_ctrl(8'h00);

      // R3 R5 R6 R7 R8: last=2, irq on, three passes, odd base bit 0
      wr_base(8'h5B);
      for (int p = 0; p < 3; p++) push_chans(8'h5B, 0, 2, 2, 1'b1);
      wr_ctrl(8'hC2);
      drain_and_stop();

      // R4: stray done while idle is ignored
      @(negedge clk); stray_done = 1'b1;
      @(negedge clk); stray_done = 1'b0;
      repeat (3) @(negedge clk);
      check(!mem_we, "R4 stray done no write", mem_we, 0);

      // R8: irq off, single channel pass, new base
      wr_base(8'h80);
      for (int p = 0; p < 3; p++) push_chans(8'h80, 0, 0, 0, 1'b0);
      wr_ctrl(8'h80);
      drain_and_stop();

      // R9: stop mid-scan, restart begins at channel 0
      wr_base(8'h22);
      push_chans(8'h22, 0, 1, 3, 1'b1);
      wr_ctrl(8'hC3);
      drain_and_stop();
      check(ctrl_rdata[7] == 1'b0, "R9 run cleared", ctrl_rdata[7], 0);
      push_chans(8'h22, 0, 3, 3, 1'b1);
      wr_ctrl(8'hC3);
      drain_and_stop();

      // R10: last-channel change mid-pass applies at wrap
      wr_base(8'hF0);
      push_chans(8'hF0, 0, 0, 1, 1'b1);
      wr_ctrl(8'hC1);
      wait (exp_q.size() == 0);
      push_chans(8'hF0, 1, 1, 1, 1'b1);
      for (int p = 0; p < 2; p++) push_chans(8'hF0, 0, 4, 4, 1'b1);
      @(negedge clk);
      ctrl_wr = 1'b1; ctrl_wdata = 8'hC4;
      @(negedge clk);
      ctrl_wr = 1'b0;
      check(ctrl_rdata == 8'hC4, "R10 new limit stored", ctrl_rdata, 8'hC4);
      drain_and_stop();

      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=0x%0h expected=0x0", exp_q.size());
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule